// File: doc/BRIEF.md
# Branch History Prediction Buffer

This block is a direct-mapped table of branch history that a fetch stage consults to guess whether a conditional branch will be taken. The table has no tags. The low-order bits of the branch address select one entry, and branches whose addresses share those bits share the entry. A lookup port takes an instruction address and returns a taken or not-taken guess in the same cycle. An update port takes the address of a resolved branch, a valid strobe and the real outcome, and it writes the new history into the selected entry at the next clock edge.

The parameter `HIST_BITS` sets the history scheme. With `HIST_BITS = 1`, each entry holds one bit that records the last outcome. With `HIST_BITS = 2`, each entry is a saturating counter that moves through four named states: `CTR_SNT` (strongly not taken, code 0), `CTR_WNT` (weakly not taken, code 1), `CTR_WT` (weakly taken, code 2) and `CTR_ST` (strongly taken, code 3). The transitions are as follows:
- A taken outcome moves the counter one step up: SNT→WNT, WNT→WT, WT→ST, and ST stays at ST.
- A not-taken outcome moves it one step down: ST→WT, WT→WNT, WNT→SNT, and SNT stays at SNT.

Because the two schemes have the same ports, they can be compared directly on a loop branch.

Top module: `bhp_predictor`

## Requirements
- R1: After reset every entry predicts not taken. A 2-bit entry starts in `CTR_WNT` (code 1), so one taken update makes it predict taken. A 1-bit entry starts at 0.
- R2: The entry index is `pc[IDX_BITS+1:2]`. Address bits [1:0] have no effect on which entry a lookup or an update selects.
- R3: `lk_taken` is combinational from `lk_pc` and shows the selected entry's current prediction in the same cycle. In 2-bit mode it is 1 exactly when the counter is in `CTR_WT` or `CTR_ST`, which are codes 2 and 3.
- R4: In 2-bit mode an update moves the counter exactly one state up for taken and one state down for not taken.
- R5: In 2-bit mode the counter saturates. A taken update in `CTR_ST` leaves it in `CTR_ST`, and a not-taken update in `CTR_SNT` leaves it in `CTR_SNT`.
- R6: In 1-bit mode the prediction after an update equals the outcome of that update.
- R7: An update is written at the rising clock edge that sees `up_valid` high. A lookup of the same entry in that same cycle returns the value from before the update. When `up_valid` is low, `up_taken` and `up_pc` change nothing.
- R8: Two addresses whose index bits match share one entry, which means their index is the same bits taken from address bits 2 and up. An update leaves every other entry unchanged.
- R9: The test pattern is a loop branch taken nine times and then not taken once, repeated. After the first pass, 2-bit mode mispredicts once per pass and 1-bit mode mispredicts twice per pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Address of the branch being fetched |
| lk_taken | output | 1 | Prediction for `lk_pc`: 1 = taken |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Real outcome of the resolved branch |

## Verification
A lookup result is due in the same cycle as its address. The bench therefore drives `lk_pc` on the falling edge and samples `lk_taken` one nanosecond later, before the next rising edge. An update has one register stage, so its effect is checked only after the rising edge that captured `up_valid`, at the following falling edge. A same-cycle lookup is sampled before that edge and must still show the old value. The loop test reads each prediction in the cycle of its own update, which follows the order in which a pipeline uses the block.

// File: rtl/bhp_pkg.sv
package bhp_pkg;
    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_state_e;
endpackage

// File: rtl/bhp_index.sv
module bhp_index #(
    parameter int PC_W     = 32,
    parameter int IDX_BITS = 6
) (
    input  logic [PC_W-1:0]     pc,
    output logic [IDX_BITS-1:0] idx
);
    localparam int LO = 2;
    localparam int HI = IDX_BITS + LO - 1;

    // word offset dropped; untagged, so high bits alias freely
    assign idx = pc[HI:LO];
endmodule

// File: rtl/bhp_next.sv
module bhp_next
    import bhp_pkg::*;
#(
    parameter int HIST_BITS = 2
) (
    input  logic [HIST_BITS-1:0] cur,
    input  logic                 taken,
    output logic [HIST_BITS-1:0] nxt
);
    generate
        if (HIST_BITS == 2) begin : g_two_bit
            ctr_state_e state_c;
            ctr_state_e state_n;

            assign state_c = ctr_state_e'(cur);

            always_comb begin
                state_n = state_c;
                unique case (state_c)
                    CTR_SNT: state_n = taken ? CTR_WNT : CTR_SNT;
                    CTR_WNT: state_n = taken ? CTR_WT  : CTR_SNT;
                    CTR_WT:  state_n = taken ? CTR_ST  : CTR_WNT;
                    CTR_ST:  state_n = taken ? CTR_ST  : CTR_WT;
                endcase
            end

            assign nxt = state_n;
        end else begin : g_one_bit
            logic last_c;
            assign last_c = cur[0];
            // last outcome replaces history regardless of last_c
            assign nxt = (last_c & 1'b0) | taken;
        end
    endgenerate
endmodule

// File: rtl/bhp_table.sv
module bhp_table #(
    parameter int          IDX_BITS = 6,
    parameter int          W        = 2,
    parameter logic [W-1:0] INIT    = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] rd_idx,
    output logic [W-1:0]        rd_data,
    input  logic [IDX_BITS-1:0] up_idx,
    output logic [W-1:0]        up_data,
    input  logic                wr_en,
    input  logic [W-1:0]        wr_data
);
    localparam int DEPTH = 1 << IDX_BITS;

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT;
        end else if (wr_en) begin
            mem_q[up_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];
    assign up_data = mem_q[up_idx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[$past(up_idx)] == $past(wr_data)); // R7

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_keep
            AST_OTHERS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && up_idx == IDX_BITS'(e)) |=> $stable(mem_q[e])); // R8
        end
    endgenerate
endmodule

// File: rtl/bhp_predictor.sv
module bhp_predictor #(
    parameter int PC_W      = 32,
    parameter int IDX_BITS  = 6,
    parameter int HIST_BITS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    localparam int                 W    = HIST_BITS;
    localparam logic [W-1:0]       INIT = (HIST_BITS == 2) ? W'(1) : W'(0);

    logic [IDX_BITS-1:0] lk_idx;
    logic [IDX_BITS-1:0] up_idx;
    logic [W-1:0]        lk_entry;
    logic [W-1:0]        cur_entry;
    logic [W-1:0]        nxt_entry;

    bhp_index #(.PC_W(PC_W), .IDX_BITS(IDX_BITS)) lk_index_i (
        .pc (lk_pc),
        .idx(lk_idx)
    );

    bhp_index #(.PC_W(PC_W), .IDX_BITS(IDX_BITS)) up_index_i (
        .pc (up_pc),
        .idx(up_idx)
    );

    bhp_table #(.IDX_BITS(IDX_BITS), .W(W), .INIT(INIT)) table_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_idx),
        .rd_data(lk_entry),
        .up_idx (up_idx),
        .up_data(cur_entry),
        .wr_en  (up_valid),
        .wr_data(nxt_entry)
    );

    bhp_next #(.HIST_BITS(HIST_BITS)) next_i (
        .cur  (cur_entry),
        .taken(up_taken),
        .nxt  (nxt_entry)
    );

    // taken half of the state space predicts taken
    assign lk_taken = lk_entry[W-1];

    generate
        if (HIST_BITS == 2) begin : g_chk2
            AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
                up_valid && cur_entry != 2'd0 && cur_entry != 2'd3 |->
                    nxt_entry == (up_taken ? cur_entry + 2'd1 : cur_entry - 2'd1)); // R4
            AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
                up_valid && up_taken && cur_entry == 2'd3 |-> nxt_entry == 2'd3); // R5
            AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
                up_valid && !up_taken && cur_entry == 2'd0 |-> nxt_entry == 2'd0); // R5
        end else begin : g_chk1
            AST_LAST_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
                up_valid |-> nxt_entry[0] == up_taken); // R6
        end
    endgenerate
endmodule

// File: tb/bhp_predictor_tb_top.sv
`timescale 1ns/1ps
module bhp_predictor_tb_top;
    localparam int PC_W = 32;
    localparam int IDX_BITS = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            up_valid = 1'b0;
    logic [PC_W-1:0] up_pc = '0;
    logic            up_taken = 1'b0;
    logic            pred2;
    logic            pred1;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bhp_predictor #(.PC_W(PC_W), .IDX_BITS(IDX_BITS), .HIST_BITS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(pred2),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    bhp_predictor #(.PC_W(PC_W), .IDX_BITS(IDX_BITS), .HIST_BITS(1)) dut1_i (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(pred1),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // update one branch; returns at the next falling edge with the write done
    task automatic upd(logic [PC_W-1:0] pc, logic t);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_taken = t;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic look(logic [PC_W-1:0] pc, output logic p2, output logic p1);
        lk_pc = pc;
        #1;
        p2 = pred2; p1 = pred1;
    endtask

    task automatic t_reset;
        logic a, b;
        for (int k = 0; k < 4; k++) begin
            look(PC_W'(k * 52), a, b);
            check("R1 reset 2-bit", a, 0);
            check("R1 reset 1-bit", b, 0);
        end
        upd(32'h0000_0040, 1'b1); // weakly NT -> one taken gives taken
        look(32'h0000_0040, a, b);
        check("R1 2-bit starts weak", a, 1);
        check("R6 1-bit after taken", b, 1);
    endtask

    task automatic t_offset_alias;
        logic a, b;
        upd(32'h0000_0013, 1'b1); // index 4 via pc[7:2]
        look(32'h0000_0010, a, b);
        check("R2 offset bits ignored 2-bit", a, 1);
        check("R2 offset bits ignored 1-bit", b, 1);
        look(32'h0000_0110, a, b); // aliases index 4
        check("R8 alias shares entry", a, 1);
        look(32'h0000_0014, a, b); // neighbour index 5
        check("R8 neighbour untouched", a, 0);
        check("R8 neighbour untouched 1-bit", b, 0);
    endtask

    task automatic t_steps_sat;
        logic a, b;
        logic [PC_W-1:0] pc = 32'h0000_0080;
        for (int k = 0; k < 5; k++) upd(pc, 1'b1);
        upd(pc, 1'b0);
        look(pc, a, b);
        check("R5 saturated top, one NT stays taken", a, 1);
        check("R6 1-bit follows NT", b, 0);
        upd(pc, 1'b0);
        look(pc, a, b);
        check("R4 step down to weak NT", a, 0);
        for (int k = 0; k < 5; k++) upd(pc, 1'b0);
        upd(pc, 1'b1);
        look(pc, a, b);
        check("R5 saturated bottom, one T stays NT", a, 0);
        check("R6 1-bit follows T", b, 1);
        upd(pc, 1'b1);
        look(pc, a, b);
        check("R3 counter 2 predicts taken", a, 1);
    endtask

    task automatic t_timing;
        logic a, b;
        logic [PC_W-1:0] pc = 32'h0000_00C0;
        @(negedge clk);
        up_valid = 1'b0; up_pc = pc; up_taken = 1'b1;
        @(negedge clk);
        look(pc, a, b);
        check("R7 no write without valid", a, 0);
        check("R7 no write without valid 1-bit", b, 0);
        up_valid = 1'b1;
        look(pc, a, b);
        check("R7 same-cycle lookup sees old", a, 0);
        @(negedge clk);
        up_valid = 1'b0;
        look(pc, a, b);
        check("R7 written at edge", a, 1);
        check("R7 written at edge 1-bit", b, 1);
    endtask

    task automatic t_loop;
        logic a, b;
        int miss2 = 0, miss1 = 0;
        logic [PC_W-1:0] pc = 32'h0000_00E0;
        for (int pass = 0; pass < 5; pass++) begin
            for (int j = 0; j < 10; j++) begin
                logic t;
                t = (j < 9);
                @(negedge clk);
                look(pc, a, b);
                if (pass > 0) begin
                    if (a != t) miss2++;
                    if (b != t) miss1++;
                end
                up_valid = 1'b1; up_pc = pc; up_taken = t;
            end
        end
        @(negedge clk);
        up_valid = 1'b0;
        check("R9 2-bit misses over 4 passes", miss2, 4);
        check("R9 1-bit misses over 4 passes", miss1, 8);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_offset_alias();
        t_steps_sat();
        t_timing();
        t_loop();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule